// File: doc/BRIEF.md
# DMA Completion Interrupt Collector

This block gathers single-cycle completion pulses from sixteen DMA channels and folds them into one interrupt line for a processor. Each pulse latches a sticky pending bit. A per-bit mask decides which pending bits may reach the interrupt line. Source bits 0 to 11 each belong to one peripheral channel, and those channels pair up as read and write directions. Bits 12 to 15 carry the completions of four converter channels.

Software reaches the block through a small register port. The port has a write strobe, an address and write data, and it returns read data one cycle after the address is presented. The mask can be loaded whole, or changed bit by bit through separate set and clear aliases. Pending bits are retired either one at a time through an acknowledge register or all together through a clear-all register. Raw and masked views of the pending bits can be read at any time without disturbing them.

Top module: `dma_done_irq_agg`

## Requirements
- R1: After a synchronous reset, every mask bit is 1, every pending bit is 0, the interrupt output is 0 and read data is 0.
- R2: A write to offset 0x8C loads the whole mask from the write data. A mask bit of 1 blocks its source and a 0 lets it through. Reading offset 0x8C returns the mask.
- R3: A write to offset 0x90 sets each mask bit whose data bit is 1. Data bits of 0 leave their mask bits unchanged.
- R4: A write to offset 0x94 clears each mask bit whose data bit is 1. Data bits of 0 leave their mask bits unchanged.
- R5: A 1 on done input bit i sets pending bit i, and the bit stays set until software retires it. Reading offset 0xA4 returns all pending bits, and the read does not change them.
- R6: A write to offset 0x9C clears each pending bit whose data bit is 1. Data bits of 0 leave their pending bits unchanged.
- R7: If a done pulse arrives in the same cycle as an acknowledge or clear-all of that bit, the bit ends up set.
- R8: Any write to offset 0x98 clears every pending bit, whatever the data.
- R9: Reading offset 0xA0 returns the pending bits AND the inverted mask. The read does not change the pending bits.
- R10: The interrupt output is a register holding the OR of the masked pending bits. It changes one cycle after the state that causes the change.
- R11: Read data is registered: it shows the value at the address presented one cycle earlier. Offsets 0x90, 0x94, 0x98, 0x9C and all unlisted offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | NUM_SRC | Register write data |
| reg_rdata | output | NUM_SRC | Registered read data |
| done_i | input | NUM_SRC | Per-channel completion pulses |
| irq_o | output | 1 | Combined interrupt, registered |

## Verification
A sweep walks each of the sixteen sources through the full path one at a time: pulse the source, read it while masked, unmask it, check the interrupt, acknowledge it and mask it again. A source wired to the wrong bit, or an alias that touches a neighbouring bit, shows up as a miscompare on one bit of the sweep. Dense patterns then tell the two mask aliases apart from a plain mask load, and they also catch set or clear writes with zero data that wrongly change the mask, and a partial acknowledge. Separate cases cover an acknowledge that lands in the same cycle as a pulse, a clear-all whose data is zero, and the one-cycle lag of the interrupt line, which a design without the output register would fail.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam logic [7:0] OFS_MASK   = 8'h8C;
  localparam logic [7:0] OFS_SET    = 8'h90;
  localparam logic [7:0] OFS_CLR    = 8'h94;
  localparam logic [7:0] OFS_CLRALL = 8'h98;
  localparam logic [7:0] OFS_ACK    = 8'h9C;
  localparam logic [7:0] OFS_MASKED = 8'hA0;
  localparam logic [7:0] OFS_RAW    = 8'hA4;

  typedef struct packed {
    logic mask_load;
    logic mask_set;
    logic mask_clr;
    logic ack;
    logic clr_all;
  } wr_strobe_t;
endpackage

// File: rtl/dma_irq_decode.sv
module dma_irq_decode
  import dma_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output wr_strobe_t        strb
);
  always_comb begin
    strb.mask_load = we && (addr == ADDR_W'(OFS_MASK));
    strb.mask_set  = we && (addr == ADDR_W'(OFS_SET));
    strb.mask_clr  = we && (addr == ADDR_W'(OFS_CLR));
    strb.ack       = we && (addr == ADDR_W'(OFS_ACK));
    strb.clr_all   = we && (addr == ADDR_W'(OFS_CLRALL));
  end
endmodule

// File: rtl/dma_irq_mask.sv
module dma_irq_mask
  import dma_irq_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  wr_strobe_t   strb,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst)                 mask <= '1;
    else if (strb.mask_load) mask <= wdata;
    else if (strb.mask_set)  mask <= mask | wdata;
    else if (strb.mask_clr)  mask <= mask & ~wdata;
  end

  a_r3_set_bits: assert property (@(posedge clk) disable iff (rst)
    strb.mask_set |=> ((mask & $past(wdata)) == $past(wdata)));
  a_r4_clr_bits: assert property (@(posedge clk) disable iff (rst)
    strb.mask_clr |=> ((mask & $past(wdata)) == '0));
  a_r3_set_keeps_others: assert property (@(posedge clk) disable iff (rst)
    strb.mask_set |=> ((mask & ~$past(wdata)) == ($past(mask) & ~$past(wdata))));
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
  import dma_irq_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  wr_strobe_t   strb,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] done,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic retire;
    assign retire = strb.clr_all || (strb.ack && wdata[i]);
    always_ff @(posedge clk) begin
      if (rst)          pend[i] <= 1'b0;
      else if (done[i]) pend[i] <= 1'b1;
      else if (retire)  pend[i] <= 1'b0;
    end
  end

  a_r7_done_sticks: assert property (@(posedge clk) disable iff (rst)
    (done != '0) |=> ((pend & $past(done)) == $past(done)));
  a_r6_ack_retires: assert property (@(posedge clk) disable iff (rst)
    strb.ack |=> ((pend & $past(wdata) & ~$past(done)) == '0));
  a_r8_clear_all: assert property (@(posedge clk) disable iff (rst)
    (strb.clr_all && done == '0) |=> (pend == '0));
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (done == '0) |=> ((pend & ~$past(pend)) == '0));
endmodule

// File: rtl/dma_done_irq_agg.sv
module dma_done_irq_agg
  import dma_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [NUM_SRC-1:0] reg_wdata,
  output logic [NUM_SRC-1:0] reg_rdata,
  input  logic [NUM_SRC-1:0] done_i,
  output logic               irq_o
);
  wr_strobe_t         strb;
  logic [NUM_SRC-1:0] mask;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] masked;
  logic [NUM_SRC-1:0] rd_next;

  dma_irq_decode #(.ADDR_W(ADDR_W)) u_decode (
    .we(reg_we), .addr(reg_addr), .strb(strb)
  );

  dma_irq_mask #(.N(NUM_SRC)) u_mask (
    .clk(clk), .rst(rst), .strb(strb), .wdata(reg_wdata), .mask(mask)
  );

  dma_irq_status #(.N(NUM_SRC)) u_status (
    .clk(clk), .rst(rst), .strb(strb), .wdata(reg_wdata),
    .done(done_i), .pend(pend)
  );

  assign masked = pend & ~mask;

  always_comb begin
    if (reg_addr == ADDR_W'(OFS_MASK))        rd_next = mask;
    else if (reg_addr == ADDR_W'(OFS_MASKED)) rd_next = masked;
    else if (reg_addr == ADDR_W'(OFS_RAW))    rd_next = pend;
    else                                      rd_next = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_o     <= 1'b0;
    end else begin
      reg_rdata <= rd_next;
      irq_o     <= |masked;
    end
  end

  a_r10_irq_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == ($past(pend & ~mask) != '0)));
  a_r2_mask_load: assert property (@(posedge clk) disable iff (rst)
    strb.mask_load |=> (mask == $past(reg_wdata)));
endmodule

// File: tb/dma_done_irq_agg_bench.sv
module dma_done_irq_agg_bench;
  localparam int N = 16;
  localparam logic [7:0] A_MASK = 8'h8C, A_SET = 8'h90, A_CLR = 8'h94,
                         A_CLRALL = 8'h98, A_ACK = 8'h9C, A_MSKD = 8'hA0,
                         A_RAW = 8'hA4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic we = 1'b0;
  logic [7:0] addr = '0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic [N-1:0] done = '0;
  logic irq;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [N-1:0] m_mask = '1;
  logic [N-1:0] m_pend = '0;
  logic [N-1:0] got;

  always #2 clk = ~clk;

  dma_done_irq_agg #(.NUM_SRC(N), .ADDR_W(8)) u_dma_done_irq_agg (
    .clk(clk), .rst(rst), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .done_i(done), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [N-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
    case (a)
      A_MASK:   m_mask = d;
      A_SET:    m_mask = m_mask | d;
      A_CLR:    m_mask = m_mask & ~d;
      A_ACK:    m_pend = m_pend & ~d;
      A_CLRALL: m_pend = '0;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [7:0] a, output logic [N-1:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic pulse(input logic [N-1:0] v);
    @(negedge clk);
    done = v;
    @(negedge clk);
    done = '0;
    m_pend = m_pend | v;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq", {15'b0, irq}, '0);
    rd(A_MASK, got); check("R1 mask", got, '1);
    rd(A_RAW, got);  check("R1 raw", got, '0);
    // R11 write-only and unlisted offsets read zero
    rd(A_SET, got);  check("R11 set reads 0", got, '0);
    rd(8'h00, got);  check("R11 unlisted reads 0", got, '0);

    for (int i = 0; i < N; i++) begin
      logic [N-1:0] b;
      b = N'(1) << i;
      pulse(b);
      check("R2 masked source no irq", {15'b0, irq}, '0);
      rd(A_RAW, got);  check("R5 raw after pulse", got, m_pend);
      rd(A_RAW, got);  check("R5 raw read non-destructive", got, m_pend);
      rd(A_MSKD, got); check("R9 masked while blocked", got, '0);
      wr(A_CLR, b);
      rd(A_MASK, got); check("R4 clr one bit", got, m_mask);
      rd(A_MSKD, got); check("R9 masked unblocked", got, b);
      check("R10 irq raised", {15'b0, irq}, 16'h0001);
      wr(A_ACK, b);
      rd(A_RAW, got);  check("R6 ack one bit", got, '0);
      check("R10 irq dropped", {15'b0, irq}, '0);
      wr(A_SET, b);
      rd(A_MASK, got); check("R3 set one bit", got, '1);
    end

    wr(A_MASK, 16'hA5C3);
    rd(A_MASK, got); check("R2 mask load", got, 16'hA5C3);
    wr(A_SET, 16'h0000);
    rd(A_MASK, got); check("R3 zero data no effect", got, 16'hA5C3);
    wr(A_CLR, 16'h0000);
    rd(A_MASK, got); check("R4 zero data no effect", got, 16'hA5C3);
    wr(A_SET, 16'h0A0C);
    rd(A_MASK, got); check("R3 set pattern", got, m_mask);
    wr(A_CLR, 16'h8181);
    rd(A_MASK, got); check("R4 clr pattern", got, m_mask);

    pulse(16'hFFFF);
    rd(A_MSKD, got); check("R9 masked pattern", got, m_pend & ~m_mask);
    check("R10 irq pattern", {15'b0, irq}, 16'h0001);
    wr(A_ACK, 16'h00F0);
    rd(A_RAW, got);  check("R6 partial ack", got, 16'hFF0F);
    wr(A_CLRALL, 16'h0000);
    rd(A_RAW, got);  check("R8 clear-all zero data", got, '0);
    check("R8 irq after clear-all", {15'b0, irq}, '0);

    // R7 collision of pulse and acknowledge
    @(negedge clk);
    we = 1'b1; addr = A_ACK; wdata = 16'h0008; done = 16'h000C;
    @(negedge clk);
    we = 1'b0; wdata = '0; done = '0;
    rd(A_RAW, got); check("R7 pulse beats ack", got, 16'h000C);
    // R7 collision of pulse and clear-all
    @(negedge clk);
    we = 1'b1; addr = A_CLRALL; wdata = 16'hFFFF; done = 16'h4000;
    @(negedge clk);
    we = 1'b0; wdata = '0; done = '0;
    rd(A_RAW, got); check("R7 pulse beats clear-all", got, 16'h4000);
    m_pend = 16'h4000;

    // R10 one-cycle latency of interrupt
    wr(A_MASK, 16'h0000);
    wr(A_CLRALL, 16'h0000);
    @(negedge clk);
    check("R10 irq idle", {15'b0, irq}, '0);
    done = 16'h0001;
    @(negedge clk);
    done = '0;
    check("R10 irq not yet", {15'b0, irq}, '0);
    @(negedge clk);
    check("R10 irq after one cycle", {15'b0, irq}, 16'h0001);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule